// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Write Behaviour

This block is a synchronous dual-port memory. Two independent access ports, A and B, each have an enable, a synchronous output preset, a write enable, an address and a data word with a few extra parity bits. Each port also has a registered data and parity output. Both ports are clocked on the rising edge of one shared clock. Every stored location holds the data word and its parity bits side by side. A read or a write of a location always moves both parts together.

A compile-time parameter picks one of three write behaviours. It decides what a writing port puts on its own output register: the new word (write-first), the word that was there before (read-first), or nothing new, so the register keeps its value (no-change). The same parameter decides what a port that reads a location sees when the other port writes that location on the same edge. In read-first mode that read returns the previous contents. In the other two modes the result is undefined: the reading port's output goes unknown and its collision flag rises for one cycle. When both ports write one location on the same edge, the stored word becomes unknown and both ports raise their flags.

Top module: `dpram_wm`

## Requirements
- R1: A port with enable 1, preset 0 and write enable 1 stores its data word and parity bits at its address on the rising edge. A later read of that address returns both parts.
- R2: A port with enable 1, preset 0 and write enable 0 loads the stored data and parity at its address into its output registers on the edge. They are visible one cycle after the inputs are applied.
- R3: In write-first mode (MODE = 0), a writing port's outputs show the incoming data and parity after the edge.
- R4: In read-first mode (MODE = 1), a writing port's outputs show the data and parity stored at the address before the write, and the new word is still stored.
- R5: In no-change mode (MODE = 2), a writing port's data and parity outputs keep their previous values.
- R6: If one port reads the address that the other port writes on the same edge, the reading port's flag is 1 for the next cycle and its outputs are undefined in modes 0 and 2. In mode 1 its flag stays 0 and it returns the previous contents.
- R7: If both ports write the same address on the same edge, both flags are 1 for the next cycle, both outputs are undefined, and the stored word at that address becomes undefined.
- R8: An enabled port with its preset at 1 loads SRST_DATA and SRST_PAR into its outputs (defaults 16'h0F0F and 2'b01). It writes nothing, even if its write enable is 1.
- R9: A port with enable 0 writes nothing, keeps its output registers and holds its flag at 0.
- R10: While rst is high, both ports' data, parity and flag outputs are cleared to 0 on the clock edge.
- R11: Accesses at different addresses never raise a flag, and each port completes its own read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of output registers and flags |
| a_en | input | 1 | Port A enable |
| a_srst | input | 1 | Port A synchronous output preset |
| a_we | input | 1 | Port A write enable |
| a_addr | input | AW | Port A address |
| a_din | input | DW | Port A write data |
| a_pin | input | PW | Port A write parity bits |
| a_dout | output | DW | Port A registered data output |
| a_pout | output | PW | Port A registered parity output |
| a_clash | output | 1 | Port A undefined-collision flag |
| b_en | input | 1 | Port B enable |
| b_srst | input | 1 | Port B synchronous output preset |
| b_we | input | 1 | Port B write enable |
| b_addr | input | AW | Port B address |
| b_din | input | DW | Port B write data |
| b_pin | input | PW | Port B write parity bits |
| b_dout | output | DW | Port B registered data output |
| b_pout | output | PW | Port B registered parity output |
| b_clash | output | 1 | Port B undefined-collision flag |

## Verification
The assertions check the rules that can be tied to the inputs of the previous edge, on every cycle. These are the clear and preset values, the silence of a disabled port, the echo in write-first mode, the hold in no-change mode, the dual-write flag, and that a flag only ever follows a same-address write by the other port. Some behaviour depends on what was stored earlier: the data returned by a plain read, the old word in read-first mode, and the fact that a preset or disabled write left the memory untouched. Only the bench's scenarios can show these. The bench runs the same sequence through all three modes at once and compares them against its own memory model.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_PRESET = 2'd1,
        ACT_READ  = 2'd2,
        ACT_WRITE = 2'd3
    } act_e;

    function automatic act_e decode_act(input logic en, input logic srst, input logic we);
        act_e r;
        if (!en)       r = ACT_IDLE;
        else if (srst) r = ACT_PRESET;
        else if (we)   r = ACT_WRITE;
        else           r = ACT_READ;
        return r;
    endfunction

    function automatic logic result_undefined(input wmode_e mode, input act_e own,
                                              input act_e other, input logic same_addr);
        logic both_write;
        logic read_hit;
        both_write = same_addr && (own == ACT_WRITE) && (other == ACT_WRITE);
        read_hit   = same_addr && (own == ACT_READ) && (other == ACT_WRITE)
                     && (mode != WM_READ_FIRST);
        return both_write || read_hit;
    endfunction

endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int WW = 18,
    parameter int AW = 10
) (
    input  logic                clk,
    input  logic [1:0]          wr_en,
    input  logic [1:0][AW-1:0]  addr,
    input  logic [1:0][WW-1:0]  wdata,
    output logic [1:0][WW-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];
    logic          dual_hit;

    assign dual_hit = wr_en[0] && wr_en[1] && (addr[0] == addr[1]);

    always_ff @(posedge clk) begin
        if (dual_hit) begin
            mem[addr[0]] <= 'x;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (wr_en[p]) mem[addr[p]] <= wdata[p];
            end
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_rd
        assign rdata[g] = mem[addr[g]];
    end

endmodule

// File: rtl/dpram_clash.sv
module dpram_clash
    import dpram_pkg::*;
#(
    parameter wmode_e MODE = WM_WRITE_FIRST,
    parameter int     AW   = 10
) (
    input  act_e [1:0]          act,
    input  logic [1:0][AW-1:0]  addr,
    output logic [1:0]          undef
);
    logic same;

    assign same = (addr[0] == addr[1]);

    for (genvar g = 0; g < 2; g++) begin : g_port
        localparam int OTHER = 1 - g;
        assign undef[g] = result_undefined(MODE, act[g], act[OTHER], same);
    end

endmodule

// File: rtl/dpram_port.sv
module dpram_port
    import dpram_pkg::*;
#(
    parameter wmode_e         MODE  = WM_WRITE_FIRST,
    parameter int             WW    = 18,
    parameter logic [WW-1:0]  PRESET = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  act_e          act,
    input  logic          undef,
    input  logic [WW-1:0] wword,
    input  logic [WW-1:0] sword,
    output logic [WW-1:0] q,
    output logic          clash
);
    logic [WW-1:0] write_view;

    always_comb begin
        case (MODE)
            WM_WRITE_FIRST: write_view = wword;
            WM_READ_FIRST:  write_view = sword;
            default:        write_view = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            clash <= 1'b0;
        end else begin
            clash <= 1'b0;
            case (act)
                ACT_PRESET: q <= PRESET;
                ACT_READ: begin
                    if (undef) begin
                        q     <= 'x;
                        clash <= 1'b1;
                    end else begin
                        q <= sword;
                    end
                end
                ACT_WRITE: begin
                    if (undef) begin
                        q     <= 'x;
                        clash <= 1'b1;
                    end else begin
                        q <= write_view;
                    end
                end
                default: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/dpram_wm.sv
module dpram_wm
    import dpram_pkg::*;
#(
    parameter wmode_e        MODE      = WM_WRITE_FIRST,
    parameter int            DW        = 16,
    parameter int            PW        = 2,
    parameter int            AW        = 10,
    parameter logic [DW-1:0] SRST_DATA = 16'h0F0F,
    parameter logic [PW-1:0] SRST_PAR  = 2'b01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_en,
    input  logic          a_srst,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_din,
    input  logic [PW-1:0] a_pin,
    output logic [DW-1:0] a_dout,
    output logic [PW-1:0] a_pout,
    output logic          a_clash,
    input  logic          b_en,
    input  logic          b_srst,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_din,
    input  logic [PW-1:0] b_pin,
    output logic [DW-1:0] b_dout,
    output logic [PW-1:0] b_pout,
    output logic          b_clash
);
    localparam int            WW     = DW + PW;
    localparam logic [WW-1:0] PRESET = {SRST_PAR, SRST_DATA};

    act_e [1:0]          act;
    logic [1:0][AW-1:0]  addr;
    logic [1:0][WW-1:0]  wword;
    logic [1:0][WW-1:0]  sword;
    logic [1:0][WW-1:0]  qword;
    logic [1:0]          wr_en;
    logic [1:0]          undef;
    logic [1:0]          clash;

    assign act[0]   = decode_act(a_en, a_srst, a_we);
    assign act[1]   = decode_act(b_en, b_srst, b_we);
    assign addr[0]  = a_addr;
    assign addr[1]  = b_addr;
    assign wword[0] = {a_pin, a_din};
    assign wword[1] = {b_pin, b_din};

    for (genvar g = 0; g < 2; g++) begin : g_wr
        assign wr_en[g] = (act[g] == ACT_WRITE);
    end

    dpram_store #(.WW(WW), .AW(AW)) u_store (
        .clk   (clk),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wword),
        .rdata (sword)
    );

    dpram_clash #(.MODE(MODE), .AW(AW)) u_clash (
        .act   (act),
        .addr  (addr),
        .undef (undef)
    );

    for (genvar g = 0; g < 2; g++) begin : g_port
        dpram_port #(.MODE(MODE), .WW(WW), .PRESET(PRESET)) u_port (
            .clk   (clk),
            .rst   (rst),
            .act   (act[g]),
            .undef (undef[g]),
            .wword (wword[g]),
            .sword (sword[g]),
            .q     (qword[g]),
            .clash (clash[g])
        );
    end

    assign {a_pout, a_dout} = qword[0];
    assign {b_pout, b_dout} = qword[1];
    assign a_clash          = clash[0];
    assign b_clash          = clash[1];

endmodule

// File: rtl/dpram_wm_chk.sv
module dpram_wm_chk
    import dpram_pkg::*;
#(
    parameter wmode_e        MODE      = WM_WRITE_FIRST,
    parameter int            DW        = 16,
    parameter int            PW        = 2,
    parameter int            AW        = 10,
    parameter logic [DW-1:0] SRST_DATA = 16'h0F0F,
    parameter logic [PW-1:0] SRST_PAR  = 2'b01
) (
    input logic          clk,
    input logic          rst,
    input logic          a_en,
    input logic          a_srst,
    input logic          a_we,
    input logic [AW-1:0] a_addr,
    input logic [DW-1:0] a_din,
    input logic [PW-1:0] a_pin,
    input logic [DW-1:0] a_dout,
    input logic [PW-1:0] a_pout,
    input logic          a_clash,
    input logic          b_en,
    input logic          b_srst,
    input logic          b_we,
    input logic [AW-1:0] b_addr,
    input logic [DW-1:0] b_din,
    input logic [PW-1:0] b_pin,
    input logic [DW-1:0] b_dout,
    input logic [PW-1:0] b_pout,
    input logic          b_clash
);
    logic a_wr, b_wr, same, dual;

    assign a_wr = a_en && !a_srst && a_we;
    assign b_wr = b_en && !b_srst && b_we;
    assign same = (a_addr == b_addr);
    assign dual = a_wr && b_wr && same;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (a_dout == '0 && a_pout == '0 && !a_clash && b_dout == '0 && !b_clash)); // R10

    AST_PRESET_VALUE: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_srst) |=> (a_dout == SRST_DATA && a_pout == SRST_PAR && !a_clash)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> (!b_clash && $stable(b_dout) && $stable(b_pout))); // R9

    AST_WF_ECHO: assert property (@(posedge clk) disable iff (rst)
        (MODE == WM_WRITE_FIRST && a_wr && !dual) |=>
        (a_dout == $past(a_din) && a_pout == $past(a_pin))); // R3

    AST_NC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (MODE == WM_NO_CHANGE && a_wr && !dual) |=> ($stable(a_dout) && $stable(a_pout))); // R5

    AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        a_clash |-> $past(b_wr && same)); // R6

    AST_RF_READ_SAFE: assert property (@(posedge clk) disable iff (rst)
        (MODE == WM_READ_FIRST && b_clash) |-> $past(b_wr)); // R6

    AST_DUAL_FLAGS: assert property (@(posedge clk) disable iff (rst)
        dual |=> (a_clash && b_clash)); // R7

endmodule

bind dpram_wm dpram_wm_chk #(
    .MODE(MODE), .DW(DW), .PW(PW), .AW(AW), .SRST_DATA(SRST_DATA), .SRST_PAR(SRST_PAR)
) u_chk (.*);

// File: tb/sim_dpram_wm.sv
module sim_dpram_wm;
    import dpram_pkg::*;

    typedef struct packed {
        logic        en;
        logic        srst;
        logic        we;
        logic [9:0]  addr;
        logic [17:0] word;
    } pin_t;

    typedef struct {
        bit          flg [3][2];
        bit          known [3][2];
        logic [17:0] val [3][2];
        string       tag;
    } exp_t;

    localparam logic [17:0] PRESET = {2'b01, 16'h0F0F};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_en = 0, a_srst = 0, a_we = 0, b_en = 0, b_srst = 0, b_we = 0;
    logic [9:0]  a_addr = '0, b_addr = '0;
    logic [15:0] a_din = '0, b_din = '0;
    logic [1:0]  a_pin = '0, b_pin = '0;

    logic [15:0] ad [3], bd [3];
    logic [1:0]  ap [3], bp [3];
    logic        ac [3], bc [3];

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    exp_t        q [$];
    logic [17:0] bm [1024];
    bit          bk [1024];
    logic [17:0] cv [3][2];
    bit          ck [3][2];

    always #2 clk = ~clk;

    dpram_wm #(.MODE(WM_WRITE_FIRST)) u0 (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_srst(a_srst), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(ad[0]), .a_pout(ap[0]), .a_clash(ac[0]),
        .b_en(b_en), .b_srst(b_srst), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(bd[0]), .b_pout(bp[0]), .b_clash(bc[0]));

    dpram_wm #(.MODE(WM_READ_FIRST)) u1 (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_srst(a_srst), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(ad[1]), .a_pout(ap[1]), .a_clash(ac[1]),
        .b_en(b_en), .b_srst(b_srst), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(bd[1]), .b_pout(bp[1]), .b_clash(bc[1]));

    dpram_wm #(.MODE(WM_NO_CHANGE)) u2 (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_srst(a_srst), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(ad[2]), .a_pout(ap[2]), .a_clash(ac[2]),
        .b_en(b_en), .b_srst(b_srst), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(bd[2]), .b_pout(bp[2]), .b_clash(bc[2]));

    function automatic pin_t mk(input bit en, input bit s, input bit w,
                                input int ad, input logic [17:0] wd);
        pin_t r;
        r.en = en; r.srst = s; r.we = w; r.addr = 10'(ad); r.word = wd;
        return r;
    endfunction

    function automatic logic [17:0] got_val(input int m, input int p);
        return (p == 0) ? {ap[m], ad[m]} : {bp[m], bd[m]};
    endfunction

    function automatic bit got_flag(input int m, input int p);
        return (p == 0) ? ac[m] : bc[m];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected outcome
    task automatic step(input pin_t a, input pin_t b, input string tag);
        pin_t        pi [2];
        exp_t        e;
        logic [17:0] old [2];
        bit          oldk [2];
        bit          wr [2];
        bit          act [2];
        bit          same, dual, undef;
        pi[0] = a; pi[1] = b;
        @(negedge clk);
        a_en = a.en; a_srst = a.srst; a_we = a.we; a_addr = a.addr;
        {a_pin, a_din} = a.word;
        b_en = b.en; b_srst = b.srst; b_we = b.we; b_addr = b.addr;
        {b_pin, b_din} = b.word;
        same = (a.addr == b.addr);
        for (int p = 0; p < 2; p++) begin
            act[p]  = pi[p].en && !pi[p].srst;
            wr[p]   = act[p] && pi[p].we;
            old[p]  = bm[pi[p].addr];
            oldk[p] = bk[pi[p].addr];
        end
        dual = wr[0] && wr[1] && same;
        for (int m = 0; m < 3; m++) begin
            for (int p = 0; p < 2; p++) begin
                undef = dual || (m != 1 && act[p] && !wr[p] && wr[1-p] && same);
                e.flg[m][p] = 1'b0;
                if (pi[p].en) begin
                    if (pi[p].srst) begin
                        cv[m][p] = PRESET; ck[m][p] = 1'b1;
                    end else if (undef) begin
                        ck[m][p] = 1'b0; e.flg[m][p] = 1'b1;
                    end else if (pi[p].we) begin
                        if (m == 0) begin cv[m][p] = pi[p].word; ck[m][p] = 1'b1; end
                        else if (m == 1) begin cv[m][p] = old[p]; ck[m][p] = oldk[p]; end
                    end else begin
                        cv[m][p] = old[p]; ck[m][p] = oldk[p];
                    end
                end
                e.known[m][p] = ck[m][p];
                e.val[m][p]   = cv[m][p];
            end
        end
        if (dual) bk[a.addr] = 1'b0;
        else begin
            for (int p = 0; p < 2; p++) begin
                if (wr[p]) begin bm[pi[p].addr] = pi[p].word; bk[pi[p].addr] = 1'b1; end
            end
        end
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares each queued expectation after the edge it belongs to
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                for (int m = 0; m < 3; m++) begin
                    for (int p = 0; p < 2; p++) begin
                        check(got_flag(m, p) == e.flg[m][p], e.tag,
                              $sformatf("mode%0d port%0d flag", m, p),
                              18'(got_flag(m, p)), 18'(e.flg[m][p]));
                        if (e.known[m][p])
                            check(got_val(m, p) === e.val[m][p], e.tag,
                                  $sformatf("mode%0d port%0d word", m, p),
                                  got_val(m, p), e.val[m][p]);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired: got timeout expected completion");
        finish_run();
    end

    initial begin
        pin_t idle;
        idle = mk(0, 0, 0, 0, 18'h0);
        for (int i = 0; i < 1024; i++) bk[i] = 1'b0;
        for (int m = 0; m < 3; m++)
            for (int p = 0; p < 2; p++) begin cv[m][p] = '0; ck[m][p] = 1'b1; end
        repeat (3) @(posedge clk);
        #1;
        // R10: cleared outputs and flags during reset
        for (int m = 0; m < 3; m++)
            for (int p = 0; p < 2; p++) begin
                check(got_val(m, p) == 18'h0, "R10", "reset word", got_val(m, p), 18'h0);
                check(!got_flag(m, p), "R10", "reset flag", 18'(got_flag(m, p)), 18'h0);
            end
        @(negedge clk);
        rst = 1'b0;

        step(mk(1, 0, 1, 5, 18'h2_1234), idle, "R1");             // first write
        step(mk(1, 0, 0, 5, 18'h0), idle, "R2");                   // plain read
        step(mk(1, 0, 1, 5, 18'h1_BEEF), idle, "R3");              // mode split: R3 R4 R5
        step(mk(1, 0, 1, 5, 18'h3_0F0E), idle, "R4");
        step(mk(1, 0, 1, 5, 18'h0_5555), idle, "R5");
        step(mk(1, 0, 0, 5, 18'h0), idle, "R1");
        step(mk(1, 0, 1, 5, 18'h2_AAAA), mk(1, 0, 0, 5, 18'h0), "R6");  // B reads A's write
        step(mk(1, 0, 0, 5, 18'h0), mk(1, 0, 1, 5, 18'h1_7777), "R6");  // A reads B's write
        step(mk(1, 0, 1, 9, 18'h1_1111), mk(1, 0, 1, 9, 18'h2_2222), "R7");
        step(mk(1, 0, 0, 9, 18'h0), mk(1, 0, 0, 9, 18'h0), "R7");
        step(mk(1, 1, 1, 5, 18'h3_DEAD), idle, "R8");              // preset, write blocked
        step(mk(1, 0, 0, 5, 18'h0), mk(1, 1, 0, 0, 18'h0), "R8");
        step(mk(0, 0, 1, 5, 18'h3_C0DE), mk(0, 0, 1, 6, 18'h1_C0DE), "R9");
        step(mk(1, 0, 0, 5, 18'h0), mk(0, 0, 0, 6, 18'h0), "R9");
        step(mk(1, 0, 1, 20, 18'h1_0A0A), mk(1, 0, 1, 21, 18'h2_0B0B), "R11");
        step(mk(1, 0, 0, 21, 18'h0), mk(1, 0, 1, 20, 18'h3_0C0C), "R11");
        step(mk(1, 0, 0, 20, 18'h0), mk(1, 0, 0, 21, 18'h0), "R11");
        step(idle, mk(1, 0, 0, 5, 18'h0), "R2");
        step(idle, idle, "R9");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule